// File: doc/BRIEF.md
# Cache-Line Doubleword ECC Checker

This block checks the error-correcting code of a cache line. The line arrives as four 64-bit doublewords, one per accepted beat. Each doubleword comes with the 8 check bits that were stored beside it. For every beat the block recomputes the 8 check bits from the data and XORs them with the stored byte to form a syndrome. A nonzero syndrome marks that doubleword as bad. The weight of the syndrome then sorts the fault into one of two classes: a single-bit error or a double-bit error.

Each check bit is the even parity of the data ANDed with a fixed 64-bit selection mask. The first mask is 0x0738C808099264FF. Each later mask is the one before it rotated left by one byte.

While a line streams in, the block accumulates a bad-doubleword mask and two line-level class flags. One cycle after the last beat of the line is accepted, it raises a one-cycle completion pulse. The block only detects and classifies errors. It does not repair data and it does not read any storage.

Top module: `ecc_line_checker`

## Requirements
- R1: Check bit i (i = 0..7) equals the XOR reduction of the data ANDed with mask i. Mask 0 is 0x0738C808099264FF, and mask i is mask 0 rotated left by 8*i bits. A doubleword whose stored byte equals this code is not flagged.
- R2: The doubleword at line offset k (k = 0..3, in arrival order) is flagged in `bad_mask` bit 3-k whenever its syndrome (computed XOR stored) is nonzero.
- R3: A syndrome with exactly one bit set is classed as single-bit. Any syndrome with two or more bits set is classed as double-bit. One doubleword never carries both classes.
- R4: `line_sbe` is the OR of the single-bit classes over the line's doublewords, and `line_dbe` is the OR of the double-bit classes. Both can be set in the same line. `bad_mask` is nonzero exactly when at least one of the two flags is set.
- R5: `done` is high for exactly one cycle, in the cycle after the fourth doubleword of a line is accepted. At that point `bad_mask`, `line_sbe` and `line_dbe` hold the complete result for the line.
- R6: A beat is accepted only on a clock edge where both `in_valid` and `in_ready` are high. Cycles without an accepted beat do not advance the line offset and do not change the results.
- R7: Accepting the first doubleword of a new line discards the previous line's mask and flags, so the results reflect only the new line.
- R8: A synchronous reset clears the mask, the flags, `done` and the line offset, and holds `in_ready` low. From the first edge after reset is released, `in_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A doubleword and its stored code are presented |
| in_ready | output | 1 | The block can accept a beat |
| in_data | input | 64 | Doubleword data |
| in_check | input | 8 | Stored check bits for the doubleword |
| bad_mask | output | 4 | Bad-doubleword mask; bit 3-k is line offset k |
| line_sbe | output | 1 | Some doubleword of the line has a single-bit class error |
| line_dbe | output | 1 | Some doubleword of the line has a double-bit class error |
| done | output | 1 | One-cycle pulse when the line result is complete |

## Verification
The assertions assume that `in_valid` and the data lines are free of X after reset. They also assume that a line starts only on a beat accepted at offset 0; any partial line left behind by a reset is abandoned.

The bench drives inputs only at falling edges. It holds `in_valid` low between lines and during deliberate idle gaps, so each line is exactly four accepted beats. The sole exception is the mid-line reset case, which checks that the partial line is dropped.

// File: rtl/ecc_line_pkg.sv
package ecc_line_pkg;

  localparam int DWORD_BITS = 64;
  localparam int CODE_BITS  = 8;
  localparam logic [DWORD_BITS-1:0] SEL_BASE = 64'h0738C808099264FF;

  typedef enum logic [1:0] {
    CLS_CLEAN  = 2'd0,
    CLS_SINGLE = 2'd1,
    CLS_MULTI  = 2'd2
  } err_class_e;

  // Rotate a selection mask left by a whole number of bytes.
  function automatic logic [DWORD_BITS-1:0] rotl_bytes(
    input logic [DWORD_BITS-1:0] m,
    input int                    nbytes
  );
    logic [DWORD_BITS-1:0] r;
    r = m;
    for (int k = 0; k < nbytes; k++) begin
      r = {r[DWORD_BITS-9:0], r[DWORD_BITS-1:DWORD_BITS-8]};
    end
    return r;
  endfunction

  // Number of set bits in a syndrome.
  function automatic int unsigned syn_weight(input logic [CODE_BITS-1:0] s);
    int unsigned w;
    w = 0;
    for (int k = 0; k < CODE_BITS; k++) begin
      w += int'(s[k]);
    end
    return w;
  endfunction

  // Sort a syndrome into a class.
  function automatic err_class_e classify(input logic [CODE_BITS-1:0] s);
    int unsigned w;
    w = syn_weight(s);
    if (w == 0)      return CLS_CLEAN;
    else if (w == 1) return CLS_SINGLE;
    else             return CLS_MULTI;
  endfunction

endpackage

// File: rtl/ecc_code_gen.sv
module ecc_code_gen
  import ecc_line_pkg::*;
#(
  parameter int                      DATA_W = DWORD_BITS,
  parameter int                      CHK_W  = CODE_BITS,
  parameter logic [DWORD_BITS-1:0]   BASE   = SEL_BASE
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  code
);

  for (genvar g = 0; g < CHK_W; g++) begin : g_bit
    localparam logic [DATA_W-1:0] SEL = rotl_bytes(BASE, g);
    assign code[g] = ^(data & SEL);
  end

endmodule

// File: rtl/ecc_syn_class.sv
module ecc_syn_class
  import ecc_line_pkg::*;
#(
  parameter int CHK_W = CODE_BITS
) (
  input  logic [CHK_W-1:0] calc,
  input  logic [CHK_W-1:0] stored,
  output logic [CHK_W-1:0] syndrome,
  output logic             err,
  output logic             sbe,
  output logic             dbe
);

  err_class_e cls;

  assign syndrome = calc ^ stored;

  always_comb begin
    cls = classify(syndrome);
    err = (cls != CLS_CLEAN);
    sbe = (cls == CLS_SINGLE);
    dbe = (cls == CLS_MULTI);
  end

endmodule

// File: rtl/ecc_line_accum.sv
module ecc_line_accum #(
  parameter int LINE_DW = 4,
  localparam int OFS_W  = (LINE_DW > 1) ? $clog2(LINE_DW) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               beat_fire,
  input  logic               beat_err,
  input  logic               beat_sbe,
  input  logic               beat_dbe,
  output logic [OFS_W-1:0]   ofs,
  output logic [LINE_DW-1:0] mask,
  output logic               any_sbe,
  output logic               any_dbe,
  output logic               line_done
);

  logic               last_beat;
  logic               first_beat;
  logic [OFS_W-1:0]   bitpos;
  logic [LINE_DW-1:0] beat_bits;

  assign last_beat  = (ofs == OFS_W'(LINE_DW - 1));
  assign first_beat = (ofs == '0);
  assign bitpos     = OFS_W'(LINE_DW - 1) - ofs;

  // Offset k lands in the mask bit counted down from the top.
  always_comb begin
    beat_bits = '0;
    if (beat_err) beat_bits[bitpos] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs       <= '0;
      mask      <= '0;
      any_sbe   <= 1'b0;
      any_dbe   <= 1'b0;
      line_done <= 1'b0;
    end else begin
      line_done <= beat_fire && last_beat;
      if (beat_fire) begin
        ofs <= last_beat ? '0 : ofs + 1'b1;
        if (first_beat) begin
          mask    <= beat_bits;
          any_sbe <= beat_sbe;
          any_dbe <= beat_dbe;
        end else begin
          mask    <= mask | beat_bits;
          any_sbe <= any_sbe | beat_sbe;
          any_dbe <= any_dbe | beat_dbe;
        end
      end
    end
  end

endmodule

// File: rtl/ecc_line_checker.sv
module ecc_line_checker
  import ecc_line_pkg::*;
#(
  parameter int DATA_W  = DWORD_BITS,
  parameter int CHK_W   = CODE_BITS,
  parameter int LINE_DW = 4,
  localparam int OFS_W  = (LINE_DW > 1) ? $clog2(LINE_DW) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [CHK_W-1:0]   in_check,
  output logic [LINE_DW-1:0] bad_mask,
  output logic               line_sbe,
  output logic               line_dbe,
  output logic               done
);

  logic               ready_q;
  logic               beat_fire;
  logic [CHK_W-1:0]   beat_code;
  logic [CHK_W-1:0]   beat_syn;
  logic               beat_err;
  logic               beat_sbe;
  logic               beat_dbe;
  logic [OFS_W-1:0]   beat_ofs;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign in_ready  = ready_q;
  assign beat_fire = in_valid && ready_q;

  ecc_code_gen #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .BASE   (SEL_BASE)
  ) u_gen (
    .data (in_data),
    .code (beat_code)
  );

  ecc_syn_class #(
    .CHK_W (CHK_W)
  ) u_cls (
    .calc     (beat_code),
    .stored   (in_check),
    .syndrome (beat_syn),
    .err      (beat_err),
    .sbe      (beat_sbe),
    .dbe      (beat_dbe)
  );

  ecc_line_accum #(
    .LINE_DW (LINE_DW)
  ) u_acc (
    .clk       (clk),
    .rst       (rst),
    .beat_fire (beat_fire),
    .beat_err  (beat_err),
    .beat_sbe  (beat_sbe),
    .beat_dbe  (beat_dbe),
    .ofs       (beat_ofs),
    .mask      (bad_mask),
    .any_sbe   (line_sbe),
    .any_dbe   (line_dbe),
    .line_done (done)
  );

endmodule

// File: rtl/ecc_line_checker_sva.sv
module ecc_line_checker_sva #(
  parameter int LINE_DW = 4,
  localparam int OFS_W  = (LINE_DW > 1) ? $clog2(LINE_DW) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_ready,
  input logic [LINE_DW-1:0] bad_mask,
  input logic               line_sbe,
  input logic               line_dbe,
  input logic               done,
  input logic               beat_fire,
  input logic               beat_err,
  input logic               beat_sbe,
  input logic               beat_dbe,
  input logic [OFS_W-1:0]   beat_ofs
);

  logic [OFS_W-1:0] pos;
  assign pos = OFS_W'(LINE_DW - 1) - beat_ofs;

  assert_err_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (beat_fire && beat_err) |=> bad_mask[$past(pos)]);

  assert_class_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({beat_sbe, beat_dbe}));

  assert_flags_need_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (line_sbe || line_dbe) |-> (bad_mask != '0));

  assert_mask_needs_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (bad_mask != '0) |-> (line_sbe || line_dbe));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(beat_fire) && ($past(beat_ofs) == OFS_W'(LINE_DW - 1))));

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !beat_fire |=> ($stable(bad_mask) && $stable(beat_ofs)));

  assert_ready_stays_R8: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready);

endmodule

bind ecc_line_checker ecc_line_checker_sva #(.LINE_DW(LINE_DW)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .bad_mask  (bad_mask),
  .line_sbe  (line_sbe),
  .line_dbe  (line_dbe),
  .done      (done),
  .beat_fire (beat_fire),
  .beat_err  (beat_err),
  .beat_sbe  (beat_sbe),
  .beat_dbe  (beat_dbe),
  .beat_ofs  (beat_ofs)
);

// File: tb/ecc_line_checker_test.sv
module ecc_line_checker_test;

  localparam logic [63:0] BASE = 64'h0738C808099264FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [7:0]  in_check = '0;
  logic [3:0]  bad_mask;
  logic        line_sbe, line_dbe, done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ecc_line_checker uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_check(in_check), .bad_mask(bad_mask),
    .line_sbe(line_sbe), .line_dbe(line_dbe), .done(done)
  );

  // Reference: mask i formed by shifting, parity by bit counting.
  function automatic logic [7:0] ref_code(input logic [63:0] d);
    logic [7:0] c;
    for (int i = 0; i < 8; i++) begin
      logic [63:0] m;
      int ones;
      m = (i == 0) ? BASE : ((BASE << (8*i)) | (BASE >> (64 - 8*i)));
      ones = 0;
      for (int b = 0; b < 64; b++) if (d[b] && m[b]) ones++;
      c[i] = ones[0];
    end
    return c;
  endfunction

  function automatic int ones8(input logic [7:0] v);
    int n = 0;
    for (int b = 0; b < 8; b++) if (v[b]) n++;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Send four beats; gap idle cycles between beats. Then check results.
  task automatic send_line(input logic [3:0][63:0] d, input logic [3:0][7:0] c,
                           input int gap, input string req);
    logic [3:0] em;
    bit es, ed;
    em = '0; es = 0; ed = 0;
    for (int k = 0; k < 4; k++) begin
      int w;
      w = ones8(ref_code(d[k]) ^ c[k]);
      if (w != 0) em[3-k] = 1'b1;
      if (w == 1) es = 1;
      if (w >= 2) ed = 1;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = d[k]; in_check = c[k];
      @(posedge clk);
      if (gap > 0 && k < 3) begin
        @(negedge clk);
        in_valid = 1'b0; in_data = ~d[k];
        repeat (gap) @(posedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(done === 1'b1, {req, " R5 done"}, int'(done), 1);
    check(bad_mask === em, {req, " R2 mask"}, int'(bad_mask), int'(em));
    check(line_sbe === es, {req, " R3 sbe"}, int'(line_sbe), int'(es));
    check(line_dbe === ed, {req, " R4 dbe"}, int'(line_dbe), int'(ed));
    @(negedge clk);
    check(done === 1'b0, {req, " R5 pulse"}, int'(done), 0);
    check(bad_mask === em, {req, " R6 hold"}, int'(bad_mask), int'(em));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0][63:0] d;
    logic [3:0][7:0]  c;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready === 1'b0, "R8 ready in reset", int'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1, "R8 ready after reset", int'(in_ready), 1);
    check(bad_mask === 4'b0, "R8 mask reset", int'(bad_mask), 0);
    check(!line_sbe && !line_dbe && !done, "R8 flags reset", int'({line_sbe,line_dbe,done}), 0);

    // R1: clean lines with walking and mixed patterns.
    for (int l = 0; l < 16; l++) begin
      for (int k = 0; k < 4; k++) begin
        d[k] = (64'h1 << ((l*4 + k) % 64)) ^ (64'h9E3779B97F4A7C15 * (l + k));
        c[k] = ref_code(d[k]);
      end
      send_line(d, c, 0, "R1 clean");
    end

    // R3/R4: every stored-code corruption pattern, four per line.
    for (int l = 0; l < 64; l++) begin
      for (int k = 0; k < 4; k++) begin
        d[k] = 64'hA5A5_0F0F_3C3C_FF00 + 64'(l * 7 + k);
        c[k] = ref_code(d[k]) ^ 8'(l*4 + k);
      end
      send_line(d, c, 0, "R3 code sweep");
    end

    // R1/R2: each single data-bit flip against a correct stored code.
    for (int l = 0; l < 16; l++) begin
      for (int k = 0; k < 4; k++) begin
        logic [63:0] good;
        good = 64'h0123_4567_89AB_CDEF ^ 64'(l);
        c[k] = ref_code(good);
        d[k] = good ^ (64'h1 << (l*4 + k));
      end
      send_line(d, c, 0, "R1 data flip");
    end

    // R6: idle gaps between beats; single error at offset 2 -> bit 1.
    for (int k = 0; k < 4; k++) begin
      d[k] = 64'hDEAD_BEEF_0000_0000 | 64'(k);
      c[k] = ref_code(d[k]);
    end
    c[2] = c[2] ^ 8'h10;
    send_line(d, c, 3, "R6 gaps");
    check(bad_mask === 4'b0010, "R2 offset2 bit1", int'(bad_mask), 2);

    // R4: single-bit at offset 0 and double-bit at offset 3 in one line.
    c[2] = ref_code(d[2]);
    c[0] = c[0] ^ 8'h01;
    c[3] = c[3] ^ 8'h81;
    send_line(d, c, 0, "R4 both");
    check(line_sbe && line_dbe && bad_mask === 4'b1001, "R4 both flags", int'(bad_mask), 9);

    // R7: clean line after a bad one shows no error.
    for (int k = 0; k < 4; k++) c[k] = ref_code(d[k]);
    send_line(d, c, 0, "R7 clear");
    check(bad_mask === 4'b0 && !line_sbe && !line_dbe, "R7 cleared", int'(bad_mask), 0);

    // R8: reset in mid-line drops partial beats.
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = d[k]; in_check = ~ref_code(d[k]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(bad_mask === 4'b0 && !done, "R8 mid-line reset", int'(bad_mask), 0);
    c[0] = c[0] ^ 8'h04;
    send_line(d, c, 0, "R8 restart");
    check(bad_mask === 4'b1000, "R8 offset restarts at 0", int'(bad_mask), 8);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule